// File: doc/BRIEF.md
# Graded Alarm Debounce Unit

This block turns raw per-channel counter samples into graded, debounced alarm events. Each monitored channel delivers a value on a one-cycle sample strobe. The block compares the value against a raise threshold for warnings, a lower clear threshold, and a critical threshold. An alarm is raised only after the condition has held for a configured number of consecutive samples. A condition that keeps holding escalates the alarm from informational to warning. A critical-level condition that holds long enough raises a critical alarm. The alarm clears only after the value has stayed below the clear threshold for its own run of consecutive samples.

The alarm of a dependent channel is held back while its parent channel is alarmed. Each channel can emit at most one event per holdoff window, and the block counts the events it blocks in that window. Every event is a record holding the free-running timestamp of the deciding sample, the channel number, the grade and a raise-or-clear flag. Records go into a small FIFO that the consumer pops. When the FIFO is full, new records are lost and a sticky flag records the loss.

Top module: `alarm_grader`

## Requirements
- R1: After reset the event FIFO is empty, the overflow flag is 0 and every suppressed count is 0.
- R2: Grades are encoded 1 informational, 2 warning, 3 critical. A value >= warn_hi for raise_cnt consecutive samples raises grade 1. Reaching esc_cnt such samples raises grade 2. A value >= crit_hi for raise_cnt consecutive samples raises grade 3. The grade never falls except by a clear.
- R3: A sample at or above warn_lo but below warn_hi neither advances nor resets the raise run. Any sample below crit_hi resets the critical run. No raise happens before the run reaches its count.
- R4: A clear needs clr_cnt consecutive samples below warn_lo. Any sample not below warn_lo restarts that run. A clear event has evt_clear_o = 1 and carries the grade being cleared.
- R5: A record appears at the FIFO output in the cycle after the clock edge that takes the deciding sample. The record carries ts_i as it was at that edge and the channel index.
- R6: Channel 1 and channel 2 depend on channel 0. While channel 0 is alarmed, a dependent channel raises nothing and logs no suppression. The pending raise occurs at that channel's first sample after the parent clears.
- R7: After a channel emits an event, it emits nothing for holdoff_i cycles. A change blocked in that window is not applied, and it adds one to that channel's suppressed count (8 bits per channel, channel i at bits [8i+7:8i]).
- R8: When several channels want an event in the same cycle, only the lowest index is granted. The others keep their state and raise at their next sample.
- R9: The FIFO holds 4 records and returns them in order. A record offered while the FIFO is full is dropped, and overflow_o then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_vld_i | input | NCH | Per-channel sample strobe |
| smp_val_i | input | NCH*VW | Per-channel sample value |
| ts_i | input | TW | Free-running timestamp |
| warn_hi_i | input | NCH*VW | Per-channel warning raise threshold |
| warn_lo_i | input | NCH*VW | Per-channel clear threshold |
| crit_hi_i | input | NCH*VW | Per-channel critical threshold |
| raise_cnt_i | input | CW | Samples needed to raise |
| esc_cnt_i | input | CW | Samples needed to escalate to warning |
| clr_cnt_i | input | CW | Samples needed to clear |
| holdoff_i | input | HW | Per-channel event holdoff in cycles |
| evt_pop_i | input | 1 | Pop the head record |
| evt_valid_o | output | 1 | FIFO holds a record |
| evt_ts_o | output | TW | Head record timestamp |
| evt_ch_o | output | CHW | Head record channel |
| evt_grade_o | output | 2 | Head record grade |
| evt_clear_o | output | 1 | Head record is a clear |
| overflow_o | output | 1 | Sticky record-loss flag |
| supp_cnt_o | output | NCH*SW | Per-channel suppressed-event counts |

## Verification
A wrong run counter shows up at the ports one sample early or late: a raise or clear record appears in the wrong cycle, or carries the wrong grade or timestamp. A holdoff or mask fault shows within one sample as a record that should not exist, or as a suppressed count that does not move. Arbitration and FIFO faults show as a missing or duplicated channel among the popped records, a reordering of those records, or an overflow flag that rises at the wrong fill level.

// File: rtl/alarm_grader_pkg.sv
package alarm_grader_pkg;
    typedef enum logic [1:0] {
        GR_NONE = 2'd0,
        GR_INFO = 2'd1,
        GR_WARN = 2'd2,
        GR_CRIT = 2'd3
    } grade_e;
endpackage

// File: rtl/alarm_chan.sv
module alarm_chan #(
    parameter int VW = 16,
    parameter int CW = 4,
    parameter int HW = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [VW-1:0] smp_val,
    input  logic [VW-1:0] warn_hi,
    input  logic [VW-1:0] warn_lo,
    input  logic [VW-1:0] crit_hi,
    input  logic [CW-1:0] raise_n,
    input  logic [CW-1:0] esc_n,
    input  logic [CW-1:0] clr_n,
    input  logic [HW-1:0] holdoff,
    input  logic          parent_alarm,
    input  logic          grant,
    output logic          req,
    output logic          ev_clear,
    output logic [1:0]    ev_grade,
    output logic          alarm,
    output logic [SW-1:0] supp_cnt
);
    import alarm_grader_pkg::*;

    typedef struct packed {
        logic [1:0]    grade;
        logic [CW-1:0] run;
        logic [CW-1:0] crit;
        logic [CW-1:0] clr;
        logic [HW-1:0] hold;
        logic [SW-1:0] supp;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic          above_w, above_c, below_lo;
    logic [CW-1:0] run_nx, crit_nx, clr_nx;
    logic [1:0]    target;
    logic          want_raise, want_clear, change;

    always_comb begin
        st_d     = st_q;
        above_w  = smp_val >= warn_hi;
        above_c  = smp_val >= crit_hi;
        below_lo = smp_val < warn_lo;
        run_nx   = st_q.run;
        crit_nx  = st_q.crit;
        clr_nx   = st_q.clr;
        if (smp_vld) begin
            if (above_w)
                run_nx = (st_q.run == '1) ? st_q.run : st_q.run + 1'b1;
            else if (below_lo)
                run_nx = '0;
            crit_nx = above_c  ? ((st_q.crit == '1) ? st_q.crit : st_q.crit + 1'b1) : '0;
            clr_nx  = below_lo ? ((st_q.clr  == '1) ? st_q.clr  : st_q.clr  + 1'b1) : '0;
        end
        if (crit_nx >= raise_n)
            target = GR_CRIT;
        else if (run_nx >= esc_n)
            target = GR_WARN;
        else if (run_nx >= raise_n)
            target = GR_INFO;
        else
            target = GR_NONE;

        want_raise = smp_vld && (target > st_q.grade);
        want_clear = smp_vld && (st_q.grade != GR_NONE) && (clr_nx >= clr_n) && !want_raise;
        change     = want_clear || (want_raise && !parent_alarm);
        req        = change && (st_q.hold == '0);
        ev_clear   = want_clear;
        ev_grade   = want_clear ? st_q.grade : target;

        st_d.run  = run_nx;
        st_d.crit = crit_nx;
        st_d.clr  = clr_nx;
        if (grant) begin
            st_d.grade = want_clear ? GR_NONE : target;
            st_d.hold  = holdoff;
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
        end
        if (change && (st_q.hold != '0) && (st_q.supp != '1))
            st_d.supp = st_q.supp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alarm    = st_q.grade != GR_NONE;
    assign supp_cnt = st_q.supp;

    AST_GRANT_OUT_OF_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (st_q.hold == '0)); // R7
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> req); // R8
    AST_NO_RAISE_UNDER_PARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !ev_clear) |-> !parent_alarm); // R6
    AST_GRADE_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.grade != GR_NONE && !(grant && ev_clear)) |=> st_q.grade >= $past(st_q.grade)); // R2
endmodule

// File: rtl/alarm_evt_fifo.sv
module alarm_evt_fifo #(
    parameter int EW    = 21,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] wdata,
    input  logic          pop,
    output logic          nonempty,
    output logic [EW-1:0] rdata,
    output logic          overflow
);
    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [NW-1:0]            cnt;
        logic                     ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     full, do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        full    = st_q.cnt == NW'(DEPTH);
        do_push = push && !full;
        do_pop  = pop && (st_q.cnt != '0);
        if (push && full)
            st_d.ovf = 1'b1;
        if (do_push) begin
            st_d.mem[st_q.wr] = wdata;
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop)
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        if (do_push && !do_pop)
            st_d.cnt = st_q.cnt + 1'b1;
        else if (do_pop && !do_push)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nonempty = st_q.cnt != '0;
    assign rdata    = st_q.mem[st_q.rd];
    assign overflow = st_q.ovf;

    AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= NW'(DEPTH)); // R9
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf); // R9
    AST_FULL_PUSH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.cnt == NW'(DEPTH) && !pop) |=> (st_q.ovf && $stable(st_q.cnt))); // R9
endmodule

// File: rtl/alarm_grader.sv
module alarm_grader #(
    parameter int NCH   = 4,
    parameter int VW    = 16,
    parameter int TW    = 16,
    parameter int CW    = 4,
    parameter int HW    = 8,
    parameter int SW    = 8,
    parameter int DEPTH = 4,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    parameter logic [NCH-1:0]     PARENT_EN  = 4'b0110,
    parameter logic [NCH*CHW-1:0] PARENT_IDX = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    smp_vld_i,
    input  logic [NCH*VW-1:0] smp_val_i,
    input  logic [TW-1:0]     ts_i,
    input  logic [NCH*VW-1:0] warn_hi_i,
    input  logic [NCH*VW-1:0] warn_lo_i,
    input  logic [NCH*VW-1:0] crit_hi_i,
    input  logic [CW-1:0]     raise_cnt_i,
    input  logic [CW-1:0]     esc_cnt_i,
    input  logic [CW-1:0]     clr_cnt_i,
    input  logic [HW-1:0]     holdoff_i,
    input  logic              evt_pop_i,
    output logic              evt_valid_o,
    output logic [TW-1:0]     evt_ts_o,
    output logic [CHW-1:0]    evt_ch_o,
    output logic [1:0]        evt_grade_o,
    output logic              evt_clear_o,
    output logic              overflow_o,
    output logic [NCH*SW-1:0] supp_cnt_o
);
    localparam int EW = TW + CHW + 3;

    logic [NCH-1:0]   req, gnt, alarm, par_al, ev_clear;
    logic [NCH*2-1:0] ev_grade;
    logic [EW-1:0]    wdata, rdata;
    logic             push;
    logic [CHW-1:0]   win_ch;
    logic [1:0]       win_grade;
    logic             win_clear;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        if (PARENT_EN[g]) begin : g_dep
            assign par_al[g] = alarm[PARENT_IDX[g*CHW +: CHW]];
        end else begin : g_root
            assign par_al[g] = 1'b0;
        end

        alarm_chan #(.VW(VW), .CW(CW), .HW(HW), .SW(SW)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .smp_vld      (smp_vld_i[g]),
            .smp_val      (smp_val_i[g*VW +: VW]),
            .warn_hi      (warn_hi_i[g*VW +: VW]),
            .warn_lo      (warn_lo_i[g*VW +: VW]),
            .crit_hi      (crit_hi_i[g*VW +: VW]),
            .raise_n      (raise_cnt_i),
            .esc_n        (esc_cnt_i),
            .clr_n        (clr_cnt_i),
            .holdoff      (holdoff_i),
            .parent_alarm (par_al[g]),
            .grant        (gnt[g]),
            .req          (req[g]),
            .ev_clear     (ev_clear[g]),
            .ev_grade     (ev_grade[g*2 +: 2]),
            .alarm        (alarm[g]),
            .supp_cnt     (supp_cnt_o[g*SW +: SW])
        );
    end

    always_comb begin
        gnt       = req & (~req + 1'b1);
        push      = |req;
        win_ch    = '0;
        win_grade = '0;
        win_clear = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (gnt[i]) begin
                win_ch    = CHW'(i);
                win_grade = ev_grade[i*2 +: 2];
                win_clear = ev_clear[i];
            end
        end
        wdata = {ts_i, win_ch, win_grade, win_clear};
    end

    alarm_evt_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .wdata    (wdata),
        .pop      (evt_pop_i),
        .nonempty (evt_valid_o),
        .rdata    (rdata),
        .overflow (overflow_o)
    );

    assign {evt_ts_o, evt_ch_o, evt_grade_o, evt_clear_o} = rdata;

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R8
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (gnt != '0 && (req & (gnt - 1'b1)) == '0)); // R8
    AST_RECORD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> evt_valid_o); // R5
endmodule

// File: tb/sim_alarm_grader.sv
module sim_alarm_grader;
    localparam int NCH = 4, VW = 16, TW = 16, CW = 4, HW = 8, SW = 8, CHW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    smp_vld = '0;
    logic [NCH*VW-1:0] smp_val = '0;
    logic [TW-1:0]     ts = '0;
    logic [CW-1:0]     raise_cnt = 4'd3, esc_cnt = 4'd5, clr_cnt = 4'd2;
    logic [HW-1:0]     holdoff = '0;
    logic              pop = 1'b0;
    logic              evt_valid, evt_clear, overflow;
    logic [TW-1:0]     evt_ts;
    logic [CHW-1:0]    evt_ch;
    logic [1:0]        evt_grade;
    logic [NCH*SW-1:0] supp;
    logic [TW-1:0]     exp_ts;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;
    always_ff @(posedge clk) ts <= ts + 1'b1;

    alarm_grader u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld), .smp_val_i(smp_val), .ts_i(ts),
        .warn_hi_i({NCH{16'd100}}), .warn_lo_i({NCH{16'd80}}), .crit_hi_i({NCH{16'd200}}),
        .raise_cnt_i(raise_cnt), .esc_cnt_i(esc_cnt), .clr_cnt_i(clr_cnt), .holdoff_i(holdoff),
        .evt_pop_i(pop), .evt_valid_o(evt_valid), .evt_ts_o(evt_ts), .evt_ch_o(evt_ch),
        .evt_grade_o(evt_grade), .evt_clear_o(evt_clear), .overflow_o(overflow),
        .supp_cnt_o(supp)
    );

    // Vector table: sample value on channel 3, then expected record (valid, grade, clear)
    localparam int NV = 14;
    localparam int VVAL [NV] = '{150, 150, 150, 150,  90, 150, 250, 250, 250,  50,  90,  50,  50, 150};
    localparam int VEV  [NV] = '{  0,   0,   1,   0,   0,   1,   0,   0,   1,   0,   0,   0,   1,   0};
    localparam int VGR  [NV] = '{  0,   0,   1,   0,   0,   2,   0,   0,   3,   0,   0,   0,   3,   0};
    localparam int VCL  [NV] = '{  0,   0,   0,   0,   0,   0,   0,   0,   0,   0,   0,   0,   1,   0};

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    // tasks start and end at a falling edge
    task automatic smp(input int ch, input int val);
        smp_vld = '0;
        smp_vld[ch] = 1'b1;
        smp_val[ch*VW +: VW] = VW'(val);
        exp_ts = ts;
        @(posedge clk);
        @(negedge clk);
        smp_vld = '0;
    endtask

    task automatic smp2(input int c1, input int v1, input int c2, input int v2);
        smp_vld = '0;
        smp_vld[c1] = 1'b1;
        smp_vld[c2] = 1'b1;
        smp_val[c1*VW +: VW] = VW'(v1);
        smp_val[c2*VW +: VW] = VW'(v2);
        exp_ts = ts;
        @(posedge clk);
        @(negedge clk);
        smp_vld = '0;
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic chk_ev(input string tag, input int ch, input int gr, input int cl, input bit tsc);
        chk({tag, " valid"}, int'(evt_valid), 1);
        chk({tag, " channel"}, int'(evt_ch), ch);
        chk({tag, " grade"}, int'(evt_grade), gr);
        chk({tag, " clear"}, int'(evt_clear), cl);
        if (tsc) chk({tag, " timestamp"}, int'(evt_ts), int'(exp_ts));
        do_pop();
    endtask

    task automatic chk_none(input string tag);
        chk({tag, " no record"}, int'(evt_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 empty during reset", int'(evt_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 empty", int'(evt_valid), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 suppressed", int'(supp), 0);

        // R2 R3 R4 R5 table walk on channel 3
        for (int k = 0; k < NV; k++) begin
            smp(3, VVAL[k]);
            if (VEV[k] != 0) chk_ev($sformatf("R2/R3/R4/R5 vec%0d", k), 3, VGR[k], VCL[k], 1'b1);
            else             chk_none($sformatf("R3/R4 vec%0d", k));
        end

        // R6 parent masking
        smp(0, 150); smp(0, 150); smp(0, 150);
        chk_ev("R6 parent raise", 0, 1, 0, 1'b1);
        smp(1, 150); smp(1, 150); smp(1, 150);
        chk_none("R6 child masked");
        chk("R6 no suppression logged", int'(supp[1*SW +: SW]), 0);
        smp(0, 50); smp(0, 50);
        chk_ev("R6 parent clear", 0, 1, 1, 1'b1);
        smp(1, 150);
        chk_ev("R6 child raise after parent clear", 1, 1, 0, 1'b1);

        // R8 arbitration: channel 3 run is at 1
        smp(2, 150); smp(2, 150); smp(3, 150);
        chk_none("R8 setup");
        smp2(2, 150, 3, 150);
        chk_ev("R8 lowest index wins", 2, 1, 0, 1'b1);
        chk_none("R8 loser not queued");
        smp(3, 150);
        chk_ev("R8 loser retries", 3, 1, 0, 1'b1);

        // R7 holdoff and suppressed count
        holdoff = 8'd20;
        smp(3, 50); smp(3, 50);
        chk_ev("R7 clear before window", 3, 1, 1, 1'b1);
        smp(3, 150); smp(3, 150); smp(3, 150);
        chk_none("R7 blocked in window");
        chk("R7 suppressed count", int'(supp[3*SW +: SW]), 1);
        repeat (25) @(negedge clk);
        smp(3, 150);
        chk_ev("R7 raise after window", 3, 1, 0, 1'b1);
        chk("R7 count held", int'(supp[3*SW +: SW]), 1);
        holdoff = 8'd0;
        repeat (25) @(negedge clk);

        // R9 overflow and order
        smp(3, 50); smp(3, 50);
        smp(3, 150); smp(3, 150); smp(3, 150);
        smp(3, 50); smp(3, 50);
        smp(3, 150); smp(3, 150); smp(3, 150);
        chk("R9 no overflow at four", int'(overflow), 0);
        smp(3, 50); smp(3, 50);
        chk("R9 overflow on fifth", int'(overflow), 1);
        chk_ev("R9 order 1", 3, 1, 1, 1'b0);
        chk_ev("R9 order 2", 3, 1, 0, 1'b0);
        chk_ev("R9 order 3", 3, 1, 1, 1'b0);
        chk_ev("R9 order 4", 3, 1, 0, 1'b0);
        chk_none("R9 fifth dropped");
        chk("R9 overflow sticky", int'(overflow), 1);

        summary();
    end
endmodule